// File: doc/BRIEF.md
# Pulse-Per-Second Divider with Armed Resynchronization

The block counts cycles of a 15.36 MHz reference clock and produces one narrow high pulse per second. Each period opens with a 10 ms high interval followed by 990 ms low. The output therefore repeats exactly once per second, and its accuracy is the accuracy of the reference. The same pulse drives several output pins, each from its own flop, to share the drive load.

The phase of the second can be moved onto an external reference.

- Pulling the active-low arm input low while the output is high puts the block into an armed state.
- The next rising edge on the sync input then restarts the period.
- The restart preloads the counter with the fixed latency of the input synchronizers and the edge detector. The restarted count therefore reads as if count zero fell on the first clock edge that saw the sync input high.
- A single resync uses up the armed state.
- Sync edges that arrive while the block is not armed have no effect.

The input clock is the only clock.

Top module: `pps_divider`

## Requirements
- R1: The output period is exactly `CLK_HZ` clock cycles. The internal count runs from 0 to `CLK_HZ-1` and then returns to 0.
- R2: In each period the output is high while the count is below `PULSE_CYCLES` and low for the rest of the period. With the defaults this is 153,600 cycles high and 15,206,400 cycles low.
- R3: All `N_OUT` output pins carry the same value on every cycle.
- R4: While reset is asserted, every output is low. After reset the count starts at `PULSE_CYCLES` (start of the low interval) when `START_AT_PULSE` is 0, and at 0 (start of the pulse) when it is 1. The output follows the count from the first clock edge after reset.
- R5: The arm input is active low and is sampled only while the output is high. A low level on it during the low interval does not arm the block.
- R6: Let edge k be the first clock edge at which the sync input is sampled high while the block is armed. At edge k+2 the count is loaded with 2 and the output goes high. The output goes low after edge k+`PULSE_CYCLES` and rises again after edge k+`CLK_HZ`.
- R7: A rising edge on the sync input while the block is not armed leaves the count and the output unchanged.
- R8: A resync clears the armed state. A later sync edge has no effect until the block is armed again.
- R9: The count never reaches or exceeds `CLK_HZ`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, 15.36 MHz by default |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_n | input | 1 | Active-low resync request, asynchronous to clk |
| sync_in | input | 1 | Resync reference; its rising edge restarts an armed divider |
| pps_out | output | N_OUT | Replicated pulse-per-second output |

## Verification
Several behaviours are checked by assertions on every cycle:
- the count stays in range and wraps at the period;
- every output pin matches the others;
- the armed state is entered only while the output is high;
- a resync happens only when armed, loads the latency constant and clears the armed state.

The bench scenarios are what show the timing seen at the ports:
- the exact edges at which the pulse rises and falls after either reset option;
- the two-cycle delay from a sync edge to the output rise, and the length of the pulse after a resync;
- that unarmed sync edges, and arm requests made during the low interval, leave the phase of the output untouched.

// File: rtl/pps_pkg.sv
package pps_pkg;
  // Arm/resync controller states.
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } arm_state_e;

  // Clock edges between the first edge that samples the sync input high and
  // the edge that reloads the counter (two synchronizer stages; edge detect is
  // combinational on the second stage).
  localparam int SYNC_LAT = 2;
endpackage

// File: rtl/pps_sync2.sv
module pps_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_n_s,   // synchronized arm request, active low
  input  logic sync_s,    // synchronized sync input
  input  logic pulse_hi,  // current output level
  output logic armed,
  output logic go         // restart the period this cycle
);
  arm_state_e state_q, state_d;
  logic       sync_d_q;
  logic       sync_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_d_q <= 1'b0;
    else        sync_d_q <= sync_s;
  end

  assign sync_rise = sync_s & ~sync_d_q;
  assign go        = (state_q == ST_ARMED) & sync_rise;

  // A resync takes priority over a new arm request in the same cycle.
  always_comb begin
    state_d = state_q;
    if (go)                       state_d = ST_IDLE;
    else if (pulse_hi && !arm_n_s) state_d = ST_ARMED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == ST_ARMED);
endmodule

// File: rtl/pps_counter.sv
module pps_counter #(
  parameter int PERIOD         = 15_360_000,
  parameter int PULSE          = 153_600,
  parameter int PRELOAD        = 2,
  parameter bit START_AT_PULSE = 1'b0,
  parameter int N_OUT          = 3,
  localparam int CW            = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic [CW-1:0]    cnt,
  output logic             pulse_hi,
  output logic [N_OUT-1:0] pins
);
  localparam logic [CW-1:0] LAST    = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HI_END  = CW'(PULSE);
  localparam logic [CW-1:0] LOAD    = CW'(PRELOAD);
  localparam logic [CW-1:0] RST_CNT = START_AT_PULSE ? '0 : CW'(PULSE);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hi_d;

  always_comb begin
    if (go)                 cnt_d = LOAD;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  assign hi_d = (cnt_d < HI_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_CNT;
    else        cnt_q <= cnt_d;
  end

  // One flop per pin so each output has its own driver.
  for (genvar i = 0; i < N_OUT; i++) begin : g_pin
    logic pin_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= hi_d;
    end
    assign pins[i] = pin_q;
  end

  assign cnt      = cnt_q;
  assign pulse_hi = pins[0];
endmodule

// File: rtl/pps_divider.sv
module pps_divider
  import pps_pkg::*;
#(
  parameter int CLK_HZ         = 15_360_000,
  parameter int PULSE_CYCLES   = 153_600,
  parameter bit START_AT_PULSE = 1'b0,
  parameter int N_OUT          = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_n,
  input  logic             sync_in,
  output logic [N_OUT-1:0] pps_out
);
  localparam int CW = $clog2(CLK_HZ);

  logic          arm_n_s;
  logic          sync_s;
  logic          armed_q;
  logic          resync_go;
  logic          pulse_hi;
  logic [CW-1:0] cnt_q;

  pps_sync2 #(.W(1), .RST_VAL(1'b1)) u_arm_sync (
    .clk(clk), .rst_n(rst_n), .d(arm_n), .q(arm_n_s)
  );

  pps_sync2 #(.W(1), .RST_VAL(1'b0)) u_sync_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_in), .q(sync_s)
  );

  pps_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_n_s(arm_n_s), .sync_s(sync_s),
    .pulse_hi(pulse_hi), .armed(armed_q), .go(resync_go)
  );

  pps_counter #(
    .PERIOD(CLK_HZ), .PULSE(PULSE_CYCLES), .PRELOAD(SYNC_LAT),
    .START_AT_PULSE(START_AT_PULSE), .N_OUT(N_OUT)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .go(resync_go), .cnt(cnt_q),
    .pulse_hi(pulse_hi), .pins(pps_out)
  );
endmodule

// File: rtl/pps_divider_chk.sv
module pps_divider_chk #(
  parameter int CLK_HZ       = 15_360_000,
  parameter int PULSE_CYCLES = 153_600,
  parameter int N_OUT        = 3,
  localparam int CW          = $clog2(CLK_HZ)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_OUT-1:0] pps_out,
  input logic [CW-1:0]    cnt,
  input logic             armed,
  input logic             go
);
  localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);

  // R9
  p_count_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R1
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LAST && !go) |=> (cnt == '0));

  // R2
  p_rise_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pps_out[0]) |-> (cnt <= CW'(pps_pkg::SYNC_LAT)));

  // R3
  p_pins_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pps_out == {N_OUT{pps_out[0]}}));

  // R5
  p_arm_when_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(pps_out[0]));

  // R6
  p_resync_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (cnt == CW'(pps_pkg::SYNC_LAT)) && pps_out[0]);

  // R7
  p_go_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> armed);

  // R8
  p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !armed);
endmodule

bind pps_divider pps_divider_chk #(
  .CLK_HZ(CLK_HZ), .PULSE_CYCLES(PULSE_CYCLES), .N_OUT(N_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pps_out(pps_out),
  .cnt(cnt_q), .armed(armed_q), .go(resync_go)
);

// File: tb/pps_divider_tb.sv
module pps_divider_tb;
  localparam int PER = 40;
  localparam int PUL = 8;
  localparam int NO  = 3;

  logic clk = 1'b0;
  logic rst_n, arm_n, sync_in;
  logic [NO-1:0] pps_a, pps_p;
  int total = 0, failed = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pps_divider #(.CLK_HZ(PER), .PULSE_CYCLES(PUL), .START_AT_PULSE(1'b0), .N_OUT(NO)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm_n(arm_n), .sync_in(sync_in), .pps_out(pps_a));

  pps_divider #(.CLK_HZ(PER), .PULSE_CYCLES(PUL), .START_AT_PULSE(1'b1), .N_OUT(NO)) u_dut_p (
    .clk(clk), .rst_n(rst_n), .arm_n(arm_n), .sync_in(sync_in), .pps_out(pps_p));

  typedef struct packed { int n; logic a; logic p; } vec_t;
  localparam vec_t VEC [12] = '{
    '{0, 1'b0, 1'b0},  '{1, 1'b0, 1'b1},  '{7, 1'b0, 1'b1},  '{8, 1'b0, 1'b0},
    '{31, 1'b0, 1'b0}, '{32, 1'b1, 1'b0}, '{39, 1'b1, 1'b0}, '{40, 1'b0, 1'b1},
    '{47, 1'b0, 1'b1}, '{48, 1'b0, 1'b0}, '{72, 1'b1, 1'b0}, '{80, 1'b0, 1'b1}
  };

  task automatic check(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s at cycle %0d: got %b expected %b", req, cyc, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic wait_rise();
    logic prev;
    do begin
      prev = pps_a[0];
      step(1);
    end while (!(pps_a[0] && !prev));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    total++;
    failed++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
  end

  initial begin
    rst_n = 1'b0; arm_n = 1'b1; sync_in = 1'b0;
    repeat (3) @(negedge clk);
    check(|pps_a, 1'b0, "R4 reset low (start-low)");
    check(|pps_p, 1'b0, "R4 reset low (start-pulse)");
    rst_n = 1'b1;

    // Free-running waveform vectors: R1 period, R2 pulse width, R4 start option.
    for (int v = 0; v < 12; v++) begin
      while (cyc < VEC[v].n) step(1);
      check(pps_a[0], VEC[v].a, "R1/R2/R4 start-low waveform");
      check(pps_p[0], VEC[v].p, "R1/R2/R4 start-pulse waveform");
      check(pps_a == {NO{pps_a[0]}}, 1'b1, "R3 pins identical");
    end

    // R7: sync edge while unarmed is ignored.
    wait_rise();                       // count 0
    step(20);
    sync_in = 1'b1;
    step(2);  check(pps_a[0], 1'b0, "R7 unarmed sync, k+1");
    step(1);  check(pps_a[0], 1'b0, "R7 unarmed sync, k+2");
    sync_in = 1'b0;
    step(16); check(pps_a[0], 1'b0, "R7 phase kept, count 39");
    step(1);  check(pps_a[0], 1'b1, "R7 phase kept, count 0");

    // R5: arm request only during the low interval does not arm.
    step(10);
    arm_n = 1'b0; step(5); arm_n = 1'b1;
    step(5);                           // count 20
    sync_in = 1'b1;
    step(3);  check(pps_a[0], 1'b0, "R5 arm while low ignored");
    sync_in = 1'b0;
    step(16); check(pps_a[0], 1'b0, "R5 phase kept, count 39");
    step(1);  check(pps_a[0], 1'b1, "R5 phase kept, count 0");

    // R6: arm while high, then resync in the low interval.
    arm_n = 1'b0; step(3); arm_n = 1'b1;
    step(17);                          // count 20
    sync_in = 1'b1;                    // edge k is the next posedge
    step(2);  check(pps_a[0], 1'b0, "R6 no rise at k+1");
    step(1);  check(pps_a[0], 1'b1, "R6 rise at k+2");
    sync_in = 1'b0;
    step(5);  check(pps_a[0], 1'b1, "R6 still high at k+7");
    step(1);  check(pps_a[0], 1'b0, "R6 low at k+PULSE");
    step(31); check(pps_a[0], 1'b0, "R6 low at k+PERIOD-1");
    step(1);  check(pps_a[0], 1'b1, "R6 rise at k+PERIOD");
    check(pps_a == {NO{pps_a[0]}}, 1'b1, "R3 pins identical after resync");

    // R8: armed state consumed; second sync ignored.
    step(10);
    sync_in = 1'b1;
    step(3);  check(pps_a[0], 1'b0, "R8 second sync ignored");
    sync_in = 1'b0;
    step(26); check(pps_a[0], 1'b0, "R8 phase kept, count 39");
    step(1);  check(pps_a[0], 1'b1, "R8 phase kept, count 0");

    summary();
  end
endmodule